// File: doc/BRIEF.md
# Serially Loaded Display Mode Register

This block holds the operating mode of a display instrument's signal paths. A host processor sends a 55-bit control word one bit at a time. The word goes into a shadow shift register. A separate load strobe then copies the whole word into the holding register, so a half-shifted word never reaches the control lines. The holding register is split into fields. These fields drive the vertical channel select, the horizontal source select, magnification, trace separation and delay-reference select. They also set the trigger source for two trigger paths, A and B.

The trigger-source lines are protected. They take a new value only on a clock edge at which the sweep holdoff input is high. A source value that is loaded outside holdoff stays pending until the first holdoff edge. When the vertical-trigger mode bit is set, both trigger paths follow the channel currently shown in the vertical sequence. This tracking is suppressed when the auto-level bit or the chop bit is also set; in that case the loaded field value is used.

All logic runs on one clock with a synchronous active-high reset. The processor's control clock arrives as a one-cycle shift enable sampled on that clock.

Top module: `modereg_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to zero on that edge. This selects vertical channel 1 (code 0), horizontal A sweep (code 0) and trigger source channel 1 (code 0) on both paths, with magnification, trace separation and delay select all off.
- R2: On an edge with `shift_en` high, the shadow register moves up one place and takes `sdi` into bit 0. After 55 shifts, the first bit sent is in bit 54. On an edge with `load` high, the holding register takes the shadow value from before that edge. Fields that are not trigger sources show on the outputs right after that edge.
- R3: Field positions in the holding word: vertical select code in bits 3:0 (0 to 3 are channels 1 to 4, 4 is ADD, 5 is readout Y); horizontal select in bits 5:4 (0 A sweep, 1 B sweep, 2 channel 1 for X-Y, 3 readout X); magnification in bit 12; trace separation in bit 13; delay select in bit 14.
- R4: Shifting with `load` low changes no output.
- R5: `trig_src_a` and `trig_src_b` hold their value across every edge at which `holdoff` is low.
- R6: Trigger path A's field is bits 8:6 and path B's is bits 11:9. Codes 0 to 3 are channels 1 to 4, 4 is ADD, 5 is line and 6 is the calibration sample. Code 7 is driven as 0. A loaded source is applied on the first edge with `holdoff` high, using the holding register value from before that edge.
- R7: When bit 15 (vertical-trigger mode) is set and bits 16 (auto level) and 17 (chop) are both clear, each holdoff edge drives both trigger paths with {0, `vseq_ch`}, where `vseq_ch` 0 to 3 means channels 1 to 4.
- R8: When bit 16 or bit 17 is set, vertical tracking is suppressed and the holdoff edge applies the trigger fields as in R6.
- R9: Bits 54:18 of the word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial control data |
| shift_en | input | 1 | Shift pulse from the processor's control clock |
| load | input | 1 | Transfers the shadow word to the holding register |
| holdoff | input | 1 | Sweep holdoff; trigger lines may change only while it is high |
| vseq_ch | input | 2 | Channel currently shown by the vertical sequencer |
| vsel | output | 4 | Vertical display select code |
| hsel | output | 2 | Horizontal display select code |
| trig_src_a | output | 3 | Trigger source, path A |
| trig_src_b | output | 3 | Trigger source, path B |
| mag_x10 | output | 1 | Horizontal X10 magnification |
| trace_sep | output | 1 | Trace separation enable |
| dly_sel | output | 1 | Delay reference select |

## Verification
The hardest case to reach is a trigger field loaded outside holdoff while the tracking bits are changing in the same word. Getting there takes a full 55-bit shift, a load, and a later holdoff edge at which the channel sequence input differs from the loaded field. The directed part of the stimulus loads words that set vertical-trigger mode, alone and together with each override bit. It then steps `vseq_ch` across holdoff pulses, so a tracked value and a field value can never coincide by chance. A long random phase mixes shift pulses, loads, holdoff and channel changes in arbitrary overlap, including a load on the same edge as holdoff.

// File: rtl/modereg_pkg.sv
package modereg_pkg;

    localparam int WORD_W = 55;
    localparam int VSEL_W = 4;
    localparam int HSEL_W = 2;
    localparam int TSRC_W = 3;
    localparam int CH_W   = 2;

    localparam int VSEL_LSB  = 0;
    localparam int HSEL_LSB  = VSEL_LSB + VSEL_W;
    localparam int SRCA_LSB  = HSEL_LSB + HSEL_W;
    localparam int SRCB_LSB  = SRCA_LSB + TSRC_W;
    localparam int MAG_BIT   = SRCB_LSB + TSRC_W;
    localparam int TSEP_BIT  = MAG_BIT + 1;
    localparam int DSEL_BIT  = TSEP_BIT + 1;
    localparam int VTRIG_BIT = DSEL_BIT + 1;
    localparam int AUTO_BIT  = VTRIG_BIT + 1;
    localparam int CHOP_BIT  = AUTO_BIT + 1;
    localparam int N_PATHS   = 2;

    typedef enum logic [TSRC_W-1:0] {
        SRC_CH1  = 3'd0,
        SRC_CH2  = 3'd1,
        SRC_CH3  = 3'd2,
        SRC_CH4  = 3'd3,
        SRC_ADD  = 3'd4,
        SRC_LINE = 3'd5,
        SRC_CAL  = 3'd6,
        SRC_RSV  = 3'd7
    } tsrc_e;

    typedef struct packed {
        logic [VSEL_W-1:0] vsel;
        logic [HSEL_W-1:0] hsel;
        logic [TSRC_W-1:0] src_a;
        logic [TSRC_W-1:0] src_b;
        logic              mag;
        logic              tsep;
        logic              dsel;
        logic              vtrig;
        logic              autolvl;
        logic              chop;
    } mode_t;

    function automatic mode_t unpack_word(input logic [WORD_W-1:0] w);
        mode_t m;
        m.vsel    = w[VSEL_LSB +: VSEL_W];
        m.hsel    = w[HSEL_LSB +: HSEL_W];
        m.src_a   = w[SRCA_LSB +: TSRC_W];
        m.src_b   = w[SRCB_LSB +: TSRC_W];
        m.mag     = w[MAG_BIT];
        m.tsep    = w[TSEP_BIT];
        m.dsel    = w[DSEL_BIT];
        m.vtrig   = w[VTRIG_BIT];
        m.autolvl = w[AUTO_BIT];
        m.chop    = w[CHOP_BIT];
        return m;
    endfunction

    function automatic logic [TSRC_W-1:0] clean_src(input logic [TSRC_W-1:0] c);
        return (c == SRC_RSV) ? SRC_CH1 : c;
    endfunction

endpackage

// File: rtl/modereg_shifter.sv
module modereg_shifter
    import modereg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdi,
    input  logic         shift_en,
    output logic [W-1:0] shadow
);

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (shift_en)
            shadow <= {shadow[W-2:0], sdi};
    end

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> shadow[0] == $past(sdi));

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(shadow));

endmodule

// File: rtl/modereg_hold.sv
module modereg_hold
    import modereg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] shadow,
    output mode_t        mode,
    output logic         track
);

    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (load)
            held <= shadow;
    end

    always_comb begin
        mode  = unpack_word(held);
        track = mode.vtrig & ~mode.autolvl & ~mode.chop;
    end

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode));

    // R2
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> mode.vsel == $past(shadow[VSEL_LSB +: VSEL_W]));

endmodule

// File: rtl/modereg_trig_gate.sv
module modereg_trig_gate
    import modereg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              holdoff,
    input  logic              track,
    input  logic [TSRC_W-1:0] field,
    input  logic [CH_W-1:0]   vseq,
    output logic [TSRC_W-1:0] src_out
);

    logic [TSRC_W-1:0] wanted;

    always_comb begin
        if (track)
            wanted = {{(TSRC_W-CH_W){1'b0}}, vseq};
        else
            wanted = clean_src(field);
    end

    always_ff @(posedge clk) begin
        if (rst)
            src_out <= SRC_CH1;
        else if (holdoff)
            src_out <= wanted;
    end

    // R5
    trig_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !holdoff |=> $stable(src_out));

    // R6
    trig_code_chk: assert property (@(posedge clk) disable iff (rst)
        src_out != SRC_RSV);

    // R7
    trig_track_chk: assert property (@(posedge clk) disable iff (rst)
        (holdoff && track) |=> src_out == {1'b0, $past(vseq)});

    // R8
    trig_field_chk: assert property (@(posedge clk) disable iff (rst)
        (holdoff && !track && $past(1'b1)) |=> src_out == clean_src($past(field)));

endmodule

// File: rtl/modereg_ctl.sv
module modereg_ctl
    import modereg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              shift_en,
    input  logic              load,
    input  logic              holdoff,
    input  logic [CH_W-1:0]   vseq_ch,
    output logic [VSEL_W-1:0] vsel,
    output logic [HSEL_W-1:0] hsel,
    output logic [TSRC_W-1:0] trig_src_a,
    output logic [TSRC_W-1:0] trig_src_b,
    output logic              mag_x10,
    output logic              trace_sep,
    output logic              dly_sel
);

    logic [W-1:0]      shadow;
    mode_t             mode;
    logic              track;
    logic [TSRC_W-1:0] fields [N_PATHS];
    logic [TSRC_W-1:0] srcs   [N_PATHS];

    modereg_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sdi      (sdi),
        .shift_en (shift_en),
        .shadow   (shadow)
    );

    modereg_hold #(.W(W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .shadow (shadow),
        .mode   (mode),
        .track  (track)
    );

    assign fields[0] = mode.src_a;
    assign fields[1] = mode.src_b;

    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
        modereg_trig_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .holdoff (holdoff),
            .track   (track),
            .field   (fields[p]),
            .vseq    (vseq_ch),
            .src_out (srcs[p])
        );
    end

    assign vsel       = mode.vsel;
    assign hsel       = mode.hsel;
    assign mag_x10    = mode.mag;
    assign trace_sep  = mode.tsep;
    assign dly_sel    = mode.dsel;
    assign trig_src_a = srcs[0];
    assign trig_src_b = srcs[1];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (vsel == '0 && hsel == '0 && trig_src_a == '0 && trig_src_b == '0));

endmodule

// File: tb/test_modereg_ctl.sv
module test_modereg_ctl;

    logic clk = 1'b0;
    logic rst, sdi, shift_en, load, holdoff;
    logic [1:0] vseq_ch;
    logic [3:0] vsel;
    logic [1:0] hsel;
    logic [2:0] trig_src_a, trig_src_b;
    logic mag_x10, trace_sep, dly_sel;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    logic [54:0] m_sr, m_hold;
    logic [2:0]  m_ta, m_tb;

    always #2.5 clk = ~clk;

    modereg_ctl i_modereg_ctl (
        .clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en), .load(load),
        .holdoff(holdoff), .vseq_ch(vseq_ch), .vsel(vsel), .hsel(hsel),
        .trig_src_a(trig_src_a), .trig_src_b(trig_src_b),
        .mag_x10(mag_x10), .trace_sep(trace_sep), .dly_sel(dly_sel)
    );

    function automatic logic [2:0] exp_src(input logic [54:0] h, input logic [2:0] f,
                                           input logic [1:0] ch);
        if (h[15] && !h[16] && !h[17]) return {1'b0, ch};
        return (f == 3'd7) ? 3'd0 : f;
    endfunction

    task automatic check(input string t);
        logic [21:0] got, exp;
        got = {vsel, hsel, trig_src_a, trig_src_b, mag_x10, trace_sep, dly_sel, 4'b0, 1'b0};
        exp = {m_hold[3:0], m_hold[5:4], m_ta, m_tb, m_hold[12], m_hold[13], m_hold[14], 4'b0, 1'b0};
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: vsel/hsel/ta/tb/mag/ts/ds actual=%h expected=%h", t, got, exp);
        end
    endtask

    task automatic tick(input logic d, input logic sh, input logic ld,
                        input logic ho, input logic [1:0] ch);
        logic [54:0] nsr, nhold;
        sdi = d; shift_en = sh; load = ld; holdoff = ho; vseq_ch = ch;
        nsr   = sh ? {m_sr[53:0], d} : m_sr;
        nhold = ld ? m_sr : m_hold;
        if (ho) begin
            m_ta = exp_src(m_hold, m_hold[8:6], ch);
            m_tb = exp_src(m_hold, m_hold[11:9], ch);
        end
        @(posedge clk);
        m_sr = nsr; m_hold = nhold;
        @(negedge clk);
        check(tag);
    endtask

    task automatic send_word(input logic [54:0] w);
        for (int i = 54; i >= 0; i--) tick(w[i], 1'b1, 1'b0, 1'b0, 2'd0);
        tick(1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    endtask

    function automatic logic [54:0] mk(input logic [3:0] v, input logic [1:0] h,
                                       input logic [2:0] a, input logic [2:0] b,
                                       input logic [5:0] flags);
        return {37'h0, flags, b, a, h, v};
    endfunction

    initial begin
        logic [63:0] r;
        logic [54:0] w1;
        logic [2:0] ta0, tb0;
        r = {32'h0, $urandom(32'h5EED)};
        sdi = 0; shift_en = 0; load = 0; holdoff = 0; vseq_ch = 0; rst = 1;
        m_sr = '0; m_hold = '0; m_ta = '0; m_tb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1"; check(tag);
        rst = 0;

        // R2 / R3 / R4: outputs untouched while shifting, fields appear at load
        tag = "R4";
        for (int i = 54; i >= 0; i--) tick(i == 54, 1'b1, 1'b0, 1'b0, 2'd0);
        tag = "R3"; send_word(mk(4'd5, 2'd3, 3'd4, 3'd5, 6'b000111));
        tag = "R2"; send_word(mk(4'd2, 2'd1, 3'd6, 3'd2, 6'b000101));
        // R5: trigger fields pending while holdoff low
        tag = "R5"; repeat (4) tick(1'b0, 1'b0, 1'b0, 1'b0, 2'd3);
        if (trig_src_a !== 3'd0 || trig_src_b !== 3'd0) begin
            fails++; $display("FAIL R5: trig a=%0d b=%0d expected 0 0", trig_src_a, trig_src_b);
        end
        vectors++;
        // R6: applied on first holdoff edge
        tag = "R6"; tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd3);
        if (trig_src_a !== 3'd6 || trig_src_b !== 3'd2) begin
            fails++; $display("FAIL R6: trig a=%0d b=%0d expected 6 2", trig_src_a, trig_src_b);
        end
        vectors++;
        // R6: reserved code 7 drives channel 1
        send_word(mk(4'd1, 2'd0, 3'd7, 3'd7, 6'b0));
        tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
        if (trig_src_a !== 3'd0 || trig_src_b !== 3'd0) begin
            fails++; $display("FAIL R6: code7 a=%0d b=%0d expected 0 0", trig_src_a, trig_src_b);
        end
        vectors++;

        // R7: vertical-trigger tracking
        tag = "R7"; send_word(mk(4'd0, 2'd0, 3'd5, 3'd4, 6'b001000));
        for (int c = 0; c < 4; c++) begin
            tick(1'b0, 1'b0, 1'b0, 1'b1, c[1:0]);
            if (trig_src_a !== {1'b0, c[1:0]} || trig_src_b !== {1'b0, c[1:0]}) begin
                fails++;
                $display("FAIL R7: a=%0d b=%0d expected %0d", trig_src_a, trig_src_b, c);
            end
            vectors++;
            tick(1'b0, 1'b0, 1'b0, 1'b0, 2'(c + 1));
        end
        // R8: auto level or chop suppress tracking
        tag = "R8"; send_word(mk(4'd0, 2'd0, 3'd5, 3'd4, 6'b011000));
        tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd2);
        if (trig_src_a !== 3'd5 || trig_src_b !== 3'd4) begin
            fails++; $display("FAIL R8: auto a=%0d b=%0d expected 5 4", trig_src_a, trig_src_b);
        end
        vectors++;
        send_word(mk(4'd0, 2'd0, 3'd1, 3'd6, 6'b101000));
        tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd3);
        if (trig_src_a !== 3'd1 || trig_src_b !== 3'd6) begin
            fails++; $display("FAIL R8: chop a=%0d b=%0d expected 1 6", trig_src_a, trig_src_b);
        end
        vectors++;

        // R9: upper bits ignored
        tag = "R9";
        for (int k = 0; k < 6; k++) begin
            r = {$urandom(), $urandom()};
            w1 = {r[54:18], 18'h0} | 55'(mk(4'(k), 2'(k), 3'(k), 3'(k + 1), 6'b0));
            send_word(w1);
            tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
            ta0 = trig_src_a; tb0 = trig_src_b;
            send_word(w1 ^ {~r[54:18], 18'h0});
            tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
            if (trig_src_a !== ta0 || trig_src_b !== tb0) begin
                fails++;
                $display("FAIL R9: a=%0d b=%0d expected %0d %0d", trig_src_a, trig_src_b, ta0, tb0);
            end
            vectors++;
        end

        // R2: random mixed traffic against the model
        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            r = {32'h0, $urandom()};
            tick(r[0], r[1] | r[2], (r[7:3] == 5'd0), (r[10:8] == 3'd0), r[12:11]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule